// File: doc/BRIEF.md
# Loop Body Cache Controller with Replay Unrolling

This block sits in the fetch stage beside the instruction cache. A loop predictor hands it a descriptor: the byte address of the loop's first instruction, the byte address of its closing branch, and how many iterations it expects. The controller looks the loop up in a small tagged store of loop bodies. When the loop is present, the controller stops forwarding instruction cache lines. It plays the stored body back one fetch line of four instructions per cycle, from the first line to the last line, once for each predicted iteration. After the final line it tells fetch to resume at the instruction following the closing branch.

When the loop is absent, the controller claims a slot and keeps forwarding the instruction cache stream unchanged. It copies the lines of the body as they go past, starting at the head line and ending at the line that holds the tail. A body that does not fit in a slot is dropped, and so is a body whose lines arrive out of order. An empty slot is chosen first. Once every slot holds a loop, slots are reused in rotation. A flush input, raised on a misprediction, stops a replay or a capture at once.

Top module: `loop_unroll_ctrl`

## Requirements
- R1: After reset no loop is held (`live_loops` = 0), `redir_valid` and `fe_from_lc` are 0, and `fe_valid` follows `ic_valid`.
- R2: While no replay is running, the fetch outputs equal the instruction cache inputs in the same cycle (`fe_valid`=`ic_valid`, `fe_addr`=`ic_addr`, `fe_line`=`ic_line`), with `fe_from_lc`=0.
- R3: A descriptor that matches no held loop (the match needs both head and tail equal) starts a capture. Lines are accepted from the line containing the head, in ascending 16-byte line order. The loop becomes held at the clock edge that accepts the line containing the tail, and `live_loops` rises by one at that edge.
- R4: A descriptor that matches a held loop with an iteration count N of 1 or more replays the body from the next cycle. The replay gives one line per cycle with `fe_valid`=1 and `fe_from_lc`=1. `fe_addr` steps from the head line to the tail line, and each `fe_line` equals the data captured for that line. The whole sequence repeats N times.
- R5: `redir_valid` is 1 for exactly one cycle, the cycle of the last line of the last iteration, with `redir_addr` = tail + 4. The next cycle returns to pass-through.
- R6: A capture is abandoned, and its slot stays empty, in two cases: a 9th line is offered (capacity is 8 lines), or a line other than the next expected one arrives after the head line. `live_loops` is then unchanged, and the same descriptor misses again.
- R7: Raising `flush` during a replay switches the outputs to the instruction cache in that same cycle with `redir_valid`=0, and the replay does not resume.
- R8: Raising `flush` during a capture ends it, and the loop is not held.
- R9: With all 4 slots held, a miss takes the oldest allocated slot in rotation. That loop stops matching, and `live_loops` reads 3 during the capture and 4 again after it completes.
- R10: Descriptors that arrive during a replay or a capture are ignored.
- R11: A matching descriptor with an iteration count of 0 starts no replay and no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Misprediction abort |
| desc_valid | input | 1 | Loop descriptor present |
| desc_head | input | 16 | Byte address of the first loop instruction |
| desc_tail | input | 16 | Byte address of the closing branch |
| desc_iters | input | 8 | Predicted iteration count |
| ic_valid | input | 1 | Instruction cache line valid |
| ic_addr | input | 16 | Line-aligned byte address of the cache line |
| ic_line | input | 128 | Four instructions from the instruction cache |
| fe_valid | output | 1 | Fetch line valid |
| fe_addr | output | 16 | Byte address of the fetch line |
| fe_line | output | 128 | Fetch line data |
| fe_from_lc | output | 1 | Line comes from the loop store |
| redir_valid | output | 1 | Resume normal fetch |
| redir_addr | output | 16 | Resume address (tail + 4) |
| live_loops | output | 3 | Number of loops held |

## Verification
Pass-through lines are due in the same cycle the instruction cache presents them. Replay lines start in the cycle after the edge that accepts a hitting descriptor and advance one per cycle. The redirect comes with the final replay line. Changes to the held-loop count show right after the edge that commits or claims a slot. The driver sets inputs just after a rising edge and queues the result expected for that cycle. The monitor compares outputs at the following falling edge, so every expectation is tied to the exact cycle it belongs to, and an extra or missing line shows up as a mismatch.

// File: rtl/lc_pkg.sv
package lc_pkg;
    parameter int ADDR_W   = 16;
    parameter int INSN_W   = 32;
    parameter int LANES    = 4;
    parameter int NLOOPS   = 4;
    parameter int MAXLINES = 8;
    parameter int CNT_W    = 8;

    localparam int LINE_W  = INSN_W * LANES;
    localparam int BYTE_SH = $clog2((INSN_W / 8) * LANES);
    localparam int LADDR_W = ADDR_W - BYTE_SH;
    localparam int SLOT_W  = (NLOOPS > 1) ? $clog2(NLOOPS) : 1;
    localparam int OFF_W   = (MAXLINES > 1) ? $clog2(MAXLINES) : 1;
    localparam int LIVE_W  = $clog2(NLOOPS + 1);

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [LADDR_W-1:0] laddr_t;
    typedef logic [LINE_W-1:0]  line_t;
    typedef logic [CNT_W-1:0]   iter_t;
    typedef logic [SLOT_W-1:0]  slot_t;
    typedef logic [OFF_W-1:0]   off_t;
    typedef logic [OFF_W:0]     cnt_t;
    typedef logic [LIVE_W-1:0]  live_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_PLAY = 2'd2
    } mode_e;

    typedef struct packed {
        addr_t head;
        addr_t tail;
        off_t  last;
    } tag_t;

    function automatic laddr_t line_of(addr_t a);
        return a[ADDR_W-1:BYTE_SH];
    endfunction

    function automatic addr_t byte_of(laddr_t l);
        return {l, {BYTE_SH{1'b0}}};
    endfunction
endpackage

// File: rtl/lc_tags.sv
module lc_tags
    import lc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  addr_t lk_head,
    input  addr_t lk_tail,
    output logic  hit,
    output slot_t hit_slot,
    output tag_t  hit_tag,
    output slot_t alloc_slot,
    input  logic  alloc_inv,
    input  logic  commit,
    input  slot_t c_slot,
    input  tag_t  c_tag,
    output live_t live
);
    logic [NLOOPS-1:0] valid_q;
    tag_t              tag_q [NLOOPS];
    slot_t             rr_q;
    logic              all_full;
    logic              have_free;
    slot_t             free_slot;

    assign all_full = &valid_q;

    always_comb begin
        hit       = 1'b0;
        hit_slot  = '0;
        have_free = 1'b0;
        free_slot = '0;
        live      = '0;
        for (int i = NLOOPS - 1; i >= 0; i--) begin
            if (valid_q[i] && tag_q[i].head == lk_head && tag_q[i].tail == lk_tail) begin
                hit      = 1'b1;
                hit_slot = slot_t'(i);
            end
            if (!valid_q[i]) begin
                have_free = 1'b1;
                free_slot = slot_t'(i);
            end
            live = live + live_t'(valid_q[i]);
        end
        hit_tag    = tag_q[hit_slot];
        alloc_slot = have_free ? free_slot : rr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else begin
            if (alloc_inv) begin
                valid_q[alloc_slot] <= 1'b0;
                if (all_full)
                    rr_q <= (rr_q == slot_t'(NLOOPS - 1)) ? '0 : rr_q + 1'b1;
            end
            if (commit)
                valid_q[c_slot] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (commit)
            tag_q[c_slot] <= c_tag;
    end

    // R9
    victim_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_inv && all_full) |=> (live == live_t'(NLOOPS - 1)));

    // R3
    commit_counts_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && !alloc_inv) |=> (live != '0));
endmodule

// File: rtl/lc_lines.sv
module lc_lines
    import lc_pkg::*;
(
    input  logic  clk,
    input  logic  we,
    input  slot_t w_slot,
    input  off_t  w_off,
    input  line_t w_data,
    input  slot_t r_slot,
    input  off_t  r_off,
    output line_t r_data
);
    localparam int DEPTH = NLOOPS * MAXLINES;

    line_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[int'(w_slot) * MAXLINES + int'(w_off)] <= w_data;
    end

    assign r_data = mem[int'(r_slot) * MAXLINES + int'(r_off)];
endmodule

// File: rtl/lc_seq.sv
module lc_seq
    import lc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   flush,
    input  logic   desc_valid,
    input  addr_t  desc_head,
    input  addr_t  desc_tail,
    input  iter_t  desc_iters,
    input  logic   ic_valid,
    input  addr_t  ic_addr,
    input  logic   hit,
    input  slot_t  hit_slot,
    input  tag_t   hit_tag,
    input  slot_t  alloc_slot,
    output mode_e  mode,
    output logic   alloc_inv,
    output logic   wr_en,
    output slot_t  wr_slot,
    output off_t   wr_off,
    output logic   commit,
    output slot_t  c_slot,
    output tag_t   c_tag,
    output slot_t  rd_slot,
    output off_t   rd_off,
    output laddr_t play_line,
    output logic   redir_valid,
    output addr_t  redir_addr
);
    mode_e  mode_q;
    slot_t  slot_q;
    addr_t  head_q;
    addr_t  tail_q;
    cnt_t   idx_q;
    off_t   last_q;
    iter_t  left_q;

    laddr_t want_line;
    logic   in_seq;
    logic   full;
    logic   abandon;
    logic   play_end;

    assign mode      = mode_q;
    assign want_line = line_of(head_q) + laddr_t'(idx_q);
    assign in_seq    = line_of(ic_addr) == want_line;
    assign full      = idx_q == cnt_t'(MAXLINES);

    assign alloc_inv = (mode_q == ST_IDLE) && desc_valid && !flush && !hit;

    assign wr_en   = (mode_q == ST_FILL) && ic_valid && !flush && in_seq && !full;
    assign wr_slot = slot_q;
    assign wr_off  = idx_q[OFF_W-1:0];
    assign abandon = (mode_q == ST_FILL) && ic_valid && (idx_q != '0) && (!in_seq || full);
    assign commit  = wr_en && (line_of(ic_addr) == line_of(tail_q));
    assign c_slot  = slot_q;
    assign c_tag   = '{head: head_q, tail: tail_q, last: idx_q[OFF_W-1:0]};

    assign rd_slot     = slot_q;
    assign rd_off      = idx_q[OFF_W-1:0];
    assign play_line   = want_line;
    assign play_end    = (mode_q == ST_PLAY) && (idx_q[OFF_W-1:0] == last_q);
    assign redir_valid = play_end && (left_q == iter_t'(1)) && !flush;
    assign redir_addr  = tail_q + addr_t'(INSN_W / 8);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= ST_IDLE;
            slot_q <= '0;
            head_q <= '0;
            tail_q <= '0;
            idx_q  <= '0;
            last_q <= '0;
            left_q <= '0;
        end else if (flush) begin
            mode_q <= ST_IDLE;
            idx_q  <= '0;
        end else begin
            unique case (mode_q)
                ST_IDLE: begin
                    if (desc_valid) begin
                        if (hit) begin
                            if (desc_iters != '0) begin
                                mode_q <= ST_PLAY;
                                slot_q <= hit_slot;
                                head_q <= desc_head;
                                tail_q <= desc_tail;
                                last_q <= hit_tag.last;
                                left_q <= desc_iters;
                                idx_q  <= '0;
                            end
                        end else begin
                            mode_q <= ST_FILL;
                            slot_q <= alloc_slot;
                            head_q <= desc_head;
                            tail_q <= desc_tail;
                            idx_q  <= '0;
                        end
                    end
                end
                ST_FILL: begin
                    if (abandon) begin
                        mode_q <= ST_IDLE;
                        idx_q  <= '0;
                    end else if (commit) begin
                        mode_q <= ST_IDLE;
                        idx_q  <= '0;
                    end else if (wr_en) begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_PLAY: begin
                    if (play_end) begin
                        idx_q <= '0;
                        if (left_q == iter_t'(1))
                            mode_q <= ST_IDLE;
                        else
                            left_q <= left_q - 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: mode_q <= ST_IDLE;
            endcase
        end
    end

    // R7
    flush_stops_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (mode_q == ST_IDLE));

    // R5
    redir_single_chk: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> (!redir_valid && mode_q == ST_IDLE));

    // R6
    fill_depth_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == ST_FILL) |-> (idx_q <= cnt_t'(MAXLINES)));

    // R10
    play_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == ST_PLAY && !play_end && !flush) |=> (mode_q == ST_PLAY));

    // R4
    play_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == ST_PLAY) |-> (idx_q[OFF_W-1:0] <= last_q && left_q != '0));
endmodule

// File: rtl/loop_unroll_ctrl.sv
module loop_unroll_ctrl
    import lc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic                  desc_valid,
    input  logic [ADDR_W-1:0]     desc_head,
    input  logic [ADDR_W-1:0]     desc_tail,
    input  logic [CNT_W-1:0]      desc_iters,
    input  logic                  ic_valid,
    input  logic [ADDR_W-1:0]     ic_addr,
    input  logic [LINE_W-1:0]     ic_line,
    output logic                  fe_valid,
    output logic [ADDR_W-1:0]     fe_addr,
    output logic [LINE_W-1:0]     fe_line,
    output logic                  fe_from_lc,
    output logic                  redir_valid,
    output logic [ADDR_W-1:0]     redir_addr,
    output logic [LIVE_W-1:0]     live_loops
);
    logic   hit;
    slot_t  hit_slot;
    tag_t   hit_tag;
    slot_t  alloc_slot;
    logic   alloc_inv;
    logic   commit;
    slot_t  c_slot;
    tag_t   c_tag;
    logic   wr_en;
    slot_t  wr_slot;
    off_t   wr_off;
    slot_t  rd_slot;
    off_t   rd_off;
    line_t  rd_data;
    laddr_t play_line;
    mode_e  mode;
    logic   play_on;

    lc_tags u_tags (
        .clk        (clk),
        .rst        (rst),
        .lk_head    (desc_head),
        .lk_tail    (desc_tail),
        .hit        (hit),
        .hit_slot   (hit_slot),
        .hit_tag    (hit_tag),
        .alloc_slot (alloc_slot),
        .alloc_inv  (alloc_inv),
        .commit     (commit),
        .c_slot     (c_slot),
        .c_tag      (c_tag),
        .live       (live_loops)
    );

    lc_lines u_lines (
        .clk    (clk),
        .we     (wr_en),
        .w_slot (wr_slot),
        .w_off  (wr_off),
        .w_data (ic_line),
        .r_slot (rd_slot),
        .r_off  (rd_off),
        .r_data (rd_data)
    );

    lc_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .desc_valid  (desc_valid),
        .desc_head   (desc_head),
        .desc_tail   (desc_tail),
        .desc_iters  (desc_iters),
        .ic_valid    (ic_valid),
        .ic_addr     (ic_addr),
        .hit         (hit),
        .hit_slot    (hit_slot),
        .hit_tag     (hit_tag),
        .alloc_slot  (alloc_slot),
        .mode        (mode),
        .alloc_inv   (alloc_inv),
        .wr_en       (wr_en),
        .wr_slot     (wr_slot),
        .wr_off      (wr_off),
        .commit      (commit),
        .c_slot      (c_slot),
        .c_tag       (c_tag),
        .rd_slot     (rd_slot),
        .rd_off      (rd_off),
        .play_line   (play_line),
        .redir_valid (redir_valid),
        .redir_addr  (redir_addr)
    );

    assign play_on    = (mode == ST_PLAY) && !flush;
    assign fe_valid   = play_on ? 1'b1 : ic_valid;
    assign fe_addr    = play_on ? byte_of(play_line) : ic_addr;
    assign fe_line    = play_on ? rd_data : ic_line;
    assign fe_from_lc = play_on;

    // R5
    redir_with_lc_chk: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> (fe_from_lc && fe_valid));

    // R2
    idle_no_redir_chk: assert property (@(posedge clk) disable iff (rst)
        !fe_from_lc |-> !redir_valid);
endmodule

// File: tb/tb_loop_unroll_ctrl.sv
module tb_loop_unroll_ctrl;
    import lc_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               flush = 1'b0;
    logic               desc_valid = 1'b0;
    logic [ADDR_W-1:0]  desc_head = '0;
    logic [ADDR_W-1:0]  desc_tail = '0;
    logic [CNT_W-1:0]   desc_iters = '0;
    logic               ic_valid = 1'b0;
    logic [ADDR_W-1:0]  ic_addr = '0;
    logic [LINE_W-1:0]  ic_line = '0;
    logic               fe_valid;
    logic [ADDR_W-1:0]  fe_addr;
    logic [LINE_W-1:0]  fe_line;
    logic               fe_from_lc;
    logic               redir_valid;
    logic [ADDR_W-1:0]  redir_addr;
    logic [LIVE_W-1:0]  live_loops;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [LINE_W-1:0] line;
        bit                lc;
        bit                rd;
        logic [ADDR_W-1:0] ra;
        string             tag;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    loop_unroll_ctrl dut (
        .clk(clk), .rst(rst), .flush(flush),
        .desc_valid(desc_valid), .desc_head(desc_head), .desc_tail(desc_tail),
        .desc_iters(desc_iters), .ic_valid(ic_valid), .ic_addr(ic_addr),
        .ic_line(ic_line), .fe_valid(fe_valid), .fe_addr(fe_addr),
        .fe_line(fe_line), .fe_from_lc(fe_from_lc), .redir_valid(redir_valid),
        .redir_addr(redir_addr), .live_loops(live_loops)
    );

    function automatic logic [LINE_W-1:0] mk_line(logic [ADDR_W-1:0] a, logic [7:0] seed);
        logic [LINE_W-1:0] l;
        for (int k = 0; k < LANES; k++)
            l[k*INSN_W +: INSN_W] = {seed, 8'(k), a};
        return l;
    endfunction

    task automatic push(logic [ADDR_W-1:0] a, logic [LINE_W-1:0] l, bit lc, bit rd,
                        logic [ADDR_W-1:0] ra, string tag);
        exp_t e;
        e.addr = a; e.line = l; e.lc = lc; e.rd = rd; e.ra = ra; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        desc_valid = 1'b0;
        ic_valid   = 1'b0;
        flush      = 1'b0;
    endtask

    task automatic beat(logic [ADDR_W-1:0] a, logic [7:0] seed, string tag);
        ic_valid = 1'b1;
        ic_addr  = a;
        ic_line  = mk_line(a, seed);
        push(a, ic_line, 1'b0, 1'b0, '0, tag);
        step();
    endtask

    task automatic desc(logic [ADDR_W-1:0] h, logic [ADDR_W-1:0] t, logic [CNT_W-1:0] n);
        desc_valid = 1'b1;
        desc_head  = h;
        desc_tail  = t;
        desc_iters = n;
        step();
    endtask

    task automatic fill(logic [ADDR_W-1:0] h, logic [ADDR_W-1:0] t, logic [7:0] seed, string tag);
        desc(h, t, 8'd1);
        for (int a = int'(h); a <= int'(t); a += 16)
            beat(ADDR_W'(a), seed, tag);
    endtask

    task automatic expect_play(logic [ADDR_W-1:0] h, logic [ADDR_W-1:0] t, int n,
                               logic [7:0] seed, string tag);
        for (int it = 0; it < n; it++) begin
            for (int a = int'(h); a <= int'(t); a += 16) begin
                bit last;
                last = (it == n - 1) && (a + 16 > int'(t));
                push(ADDR_W'(a), mk_line(ADDR_W'(a), seed), 1'b1, last, t + 16'd4, tag);
                step();
            end
        end
    endtask

    task automatic check_live(int exp, string tag);
        checks++;
        if (int'(live_loops) != exp) begin
            errors++;
            $display("FAIL %s live_loops actual %0d expected %0d", tag, live_loops, exp);
        end
    endtask

    always @(negedge clk) begin
        exp_t e;
        if (!rst && !done) begin
            if (fe_valid) begin
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected line addr %h lc %0d expected none", fe_addr, fe_from_lc);
                end else begin
                    e = q.pop_front();
                    if (fe_addr !== e.addr || fe_line !== e.line || fe_from_lc !== e.lc ||
                        redir_valid !== e.rd || (e.rd && redir_addr !== e.ra)) begin
                        errors++;
                        $display("FAIL %s actual addr %h lc %0d redir %0d/%h line %h expected addr %h lc %0d redir %0d/%h line %h",
                                 e.tag, fe_addr, fe_from_lc, redir_valid, redir_addr, fe_line,
                                 e.addr, e.lc, e.rd, e.ra, e.line);
                    end
                end
            end else if (redir_valid) begin
                checks++;
                errors++;
                $display("FAIL R5 redirect without line actual 1 expected 0");
            end
        end
    end

    initial begin
        #40000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        check_live(0, "R1");
        checks++;
        if (fe_valid !== 1'b0 || fe_from_lc !== 1'b0 || redir_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 outputs actual %0d%0d%0d expected 000", fe_valid, fe_from_lc, redir_valid);
        end
        // R2 pass-through
        beat(16'h0040, 8'h11, "R2");
        beat(16'h0050, 8'h12, "R2");
        // R3 capture loop A (3 lines), a line before the head is not captured
        desc(16'h0100, 16'h012C, 8'd2);
        beat(16'h00F0, 8'hEE, "R3");
        beat(16'h0100, 8'hA1, "R3");
        beat(16'h0110, 8'hA1, "R3");
        check_live(0, "R3");
        beat(16'h0120, 8'hA1, "R3");
        check_live(1, "R3");
        // R4 R5 replay twice, R10 descriptor during replay ignored
        desc(16'h0100, 16'h012C, 8'd2);
        for (int it = 0; it < 2; it++) begin
            for (int a = 16'h0100; a <= 16'h0120; a += 16) begin
                if (it == 0 && a == 16'h0120) begin
                    desc_valid = 1'b1; desc_head = 16'h0200; desc_tail = 16'h021C; desc_iters = 8'd1;
                end
                push(ADDR_W'(a), mk_line(ADDR_W'(a), 8'hA1), 1'b1, (it == 1 && a == 16'h0120),
                     16'h0130, "R4");
                step();
            end
        end
        beat(16'h0200, 8'h22, "R5");
        beat(16'h0210, 8'h22, "R10");
        check_live(1, "R10");
        // R6 capacity overflow: 9th line abandons
        desc(16'h0400, 16'h04FC, 8'd1);
        for (int a = 16'h0400; a <= 16'h0480; a += 16)
            beat(ADDR_W'(a), 8'h44, "R6");
        check_live(1, "R6");
        desc(16'h0400, 16'h04FC, 8'd1);
        beat(16'h07F0, 8'h77, "R6");
        step();
        flush = 1'b1; step();
        // R6 out-of-order line abandons
        desc(16'h0600, 16'h062C, 8'd1);
        beat(16'h0600, 8'h66, "R6");
        beat(16'h0620, 8'h66, "R6");
        beat(16'h0610, 8'h66, "R6");
        beat(16'h0620, 8'h66, "R6");
        check_live(1, "R6");
        desc(16'h0600, 16'h062C, 8'd1);
        beat(16'h07F0, 8'h77, "R6");
        flush = 1'b1; step();
        // R8 flush during capture
        desc(16'h0500, 16'h051C, 8'd1);
        beat(16'h0500, 8'h55, "R8");
        flush = 1'b1; step();
        beat(16'h0510, 8'h55, "R8");
        check_live(1, "R8");
        desc(16'h0500, 16'h051C, 8'd1);
        beat(16'h07E0, 8'h77, "R8");
        flush = 1'b1; step();
        // R11 zero iterations on a hit
        desc(16'h0100, 16'h012C, 8'd0);
        beat(16'h0100, 8'h99, "R11");
        check_live(1, "R11");
        // R7 flush during replay
        desc(16'h0100, 16'h012C, 8'd3);
        for (int k = 0; k < 4; k++) begin
            int a;
            a = 16'h0100 + 16 * (k % 3);
            push(ADDR_W'(a), mk_line(ADDR_W'(a), 8'hA1), 1'b1, 1'b0, '0, "R7");
            step();
        end
        flush = 1'b1;
        beat(16'h0900, 8'h90, "R7");
        beat(16'h0910, 8'h90, "R7");
        step();
        // R9 fill all slots then replace in rotation
        fill(16'h0200, 16'h021C, 8'hB2, "R9");
        fill(16'h0300, 16'h030C, 8'hC3, "R9");
        fill(16'h0700, 16'h072C, 8'hD4, "R9");
        check_live(4, "R9");
        desc(16'h0800, 16'h081C, 8'd1);
        check_live(3, "R9");
        beat(16'h0800, 8'hE5, "R9");
        beat(16'h0810, 8'hE5, "R9");
        check_live(4, "R9");
        desc(16'h0200, 16'h021C, 8'd1);
        expect_play(16'h0200, 16'h021C, 1, 8'hB2, "R4");
        desc(16'h0300, 16'h030C, 8'd2);
        expect_play(16'h0300, 16'h030C, 2, 8'hC3, "R5");
        desc(16'h0800, 16'h081C, 8'd1);
        expect_play(16'h0800, 16'h081C, 1, 8'hE5, "R3");
        desc(16'h0100, 16'h012C, 8'd1);
        beat(16'h0100, 8'h99, "R9");
        flush = 1'b1; step();
        step();
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R4 pending lines actual %0d expected 0", q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule